// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

A synthesizable, shallow model of a synchronous static RAM built for full bus rate. Every input is captured on the rising clock edge. Reads and writes may be issued on consecutive cycles in any mix, and no idle cycle is needed when the data bus changes direction. The bus is shared without a gap because write data arrives a fixed number of cycles after its write command: one cycle in flow-through mode and two in pipelined mode. That timing matches the slot a read would use for its data.

A command is either a load, which starts a new access at the presented address, or a continue, which steps an internal four-beat burst counter. The burst order is linear or interleaved, chosen by a static pin. Writes that are still waiting for their data sit in a short pipeline. A pipelined read that targets such a write is served from the incoming data, merged byte by byte. Clock enable freezes the whole block. A sleep request takes effect two enabled edges after it is sampled. An output enable releases the data outputs at once, without waiting for a clock.

Top module: `lw_sram`

## Requirements
- R1: On a rising edge with clk_en_i=1, adv_i=0 and all three chip_sel_i bits high, a new access starts at addr_i. It is a write when we_i=1 and a read when we_i=0.
- R2: Pipelined mode (flow_i=0). For a read command at edge n, dq_drive_o=1 and dout_o carries the word between edge n+1 and edge n+2. For a write command at edge n, din_i is taken at edge n+2.
- R3: Flow-through mode (flow_i=1). For a read command at edge n, the word is driven between edge n and edge n+1. For a write command at edge n, din_i is taken at edge n+1.
- R4: Read and write commands may alternate on consecutive edges with no idle cycle, and each read returns the correct word.
- R5: In pipelined mode, a read issued the edge after a write to the same address returns that write's data for the enabled bytes and the old array contents for the other bytes.
- R6: A word is NUM_BYTES bytes of 9 bits, with byte b at bits [9b+8:9b]. byte_we_i[b]=1, sampled with each write command or write continue, writes byte b. Bytes whose enable is 0 are left unchanged.
- R7: On an enabled edge with adv_i=1, the previous read or write continues at the next beat, and chip_sel_i and we_i are ignored. The two low address bits of beat k are (a+k) mod 4 when lin_burst_i=1 and a XOR k when lin_burst_i=0. The upper address bits stay fixed.
- R8: A load with any chip_sel_i bit low is a deselect: the array is not touched, nothing is driven in that command's data slot, and a continue that follows it is also a deselect.
- R9: An edge with clk_en_i=0 changes no state, and dout_o and dq_drive_o hold.
- R10: After sleep_i=1 is sampled at enabled edge e, commands from edge e+2 onward are treated as deselects and dq_drive_o=0. Array contents are kept. Normal operation resumes two enabled edges after sleep_i=0 is sampled.
- R11: oe_i=0 forces dq_drive_o=0 and dout_o=0 combinationally, at any time.
- R12: During and after reset, no access is pending, dq_drive_o=0 and dout_o=0. dout_o is always 0 whenever dq_drive_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable; 0 freezes the block |
| chip_sel_i | input | 3 | Chip selects, all must be 1 to select |
| adv_i | input | 1 | 1 continues the burst, 0 loads a new address |
| we_i | input | 1 | 1 write, 0 read (load cycles only) |
| byte_we_i | input | NUM_BYTES | Per-byte write enables |
| addr_i | input | ADDR_W | Word address |
| din_i | input | NUM_BYTES*BYTE_W | Write data |
| flow_i | input | 1 | Static mode: 1 flow-through, 0 pipelined |
| lin_burst_i | input | 1 | Static burst order: 1 linear, 0 interleaved |
| sleep_i | input | 1 | Sleep request |
| oe_i | input | 1 | Asynchronous output enable |
| dout_o | output | NUM_BYTES*BYTE_W | Read data, 0 when not driven |
| dq_drive_o | output | 1 | 1 while the data bus is driven; 0 stands for high impedance |

## Verification
The bench looks for the cases where the data slots of neighbouring commands interact. These include a read issued right behind a write to the same word, where a model without the bypass would return the stale word, and a partial byte write, where a merge done on the wrong lanes would corrupt the untouched byte. Bursts are run in both orders from a non-aligned start address, so a counter that does not wrap, or that mixes up the two orders, returns the words in the wrong sequence. Three further cases are covered. A deselected or slept write is followed by a read of that word, which shows whether its data slot still wrote the array. A frozen clock with a new command on the pins shows whether the output stayed put. Dropping the output enable mid-cycle shows whether the outputs wait for a clock before they release.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits of a burst beat
  function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                         input logic [1:0] beat,
                                         input logic       linear);
    logic [1:0] sum;
    sum = base + beat;
    return linear ? sum : (base ^ beat);
  endfunction

endpackage

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic                 asleep_i,
  input  logic                 adv_i,
  input  logic                 we_i,
  input  logic                 sel_i,
  input  logic [NUM_BYTES-1:0] be_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 linear_i,
  output op_e                  op_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [NUM_BYTES-1:0] be_o
);

  op_e                  op_q;
  logic [ADDR_W-1:0]    base_q;
  logic [1:0]           cnt_q;
  logic [NUM_BYTES-1:0] be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      be_q   <= '0;
    end else if (step_i) begin
      if (!adv_i) begin
        if (sel_i && !asleep_i) begin
          op_q   <= we_i ? OP_WRITE : OP_READ;
          base_q <= addr_i;
          cnt_q  <= '0;
          be_q   <= be_i;
        end else begin
          op_q <= OP_IDLE;
        end
      end else if (op_q != OP_IDLE && !asleep_i) begin
        cnt_q <= cnt_q + 2'd1;
        be_q  <= be_i;
      end else begin
        op_q <= OP_IDLE;
      end
    end
  end

  assign op_o   = op_q;
  assign addr_o = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], cnt_q, linear_i)};
  assign be_o   = be_q;

  assert_burst_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && adv_i && op_q != OP_IDLE && !asleep_i) |=>
      (cnt_q == $past(cnt_q) + 2'd1 && op_q == $past(op_q) && base_q == $past(base_q)));

  assert_deselect_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !adv_i && !sel_i) |=> (op_q == OP_IDLE));

  assert_hold_on_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(op_q) && $stable(cnt_q) && $stable(base_q) && $stable(be_q)));

  assert_sleep_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && asleep_i) |=> (op_q == OP_IDLE));

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 2,
  parameter int BYTE_W    = 9
) (
  input  logic                        clk_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           waddr_i,
  input  logic [NUM_BYTES-1:0]        wbe_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]           raddr_i,
  output logic [NUM_BYTES*BYTE_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[b]) bank[waddr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
    end

    assign rdata_o[b*BYTE_W +: BYTE_W] = bank[raddr_i];
  end

endmodule

// File: rtl/lw_sram_rdpath.sv
module lw_sram_rdpath #(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 2,
  parameter int BYTE_W    = 9
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        step_i,
  input  logic                        flow_i,
  input  logic                        rd_op_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] arr_data_i,
  input  logic                        wr_fire_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [NUM_BYTES-1:0]        wr_be_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] wr_data_i,
  output logic                        valid_o,
  output logic [NUM_BYTES*BYTE_W-1:0] data_o
);

  localparam int DATA_W = NUM_BYTES * BYTE_W;

  logic              hit;
  logic [DATA_W-1:0] merged;
  logic              q_valid;
  logic [DATA_W-1:0] q_data;

  // write landing on this edge to the word being read: forward it
  assign hit = wr_fire_i && (wr_addr_i == rd_addr_i);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_merge
    assign merged[b*BYTE_W +: BYTE_W] = (hit && wr_be_i[b]) ?
        wr_data_i[b*BYTE_W +: BYTE_W] : arr_data_i[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else if (step_i) begin
      q_valid <= rd_op_i;
      if (rd_op_i) q_data <= merged;
    end
  end

  assign valid_o = flow_i ? rd_op_i    : q_valid;
  assign data_o  = flow_i ? arr_data_i : q_data;

  assert_bypass_lane0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !flow_i && rd_op_i && wr_fire_i && wr_addr_i == rd_addr_i && wr_be_i[0]) |=>
      (q_data[BYTE_W-1:0] == $past(wr_data_i[BYTE_W-1:0])));

  assert_pipe_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !flow_i && !rd_op_i) |=> !q_valid);

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 2,
  parameter int BYTE_W    = 9,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clk_en_i,
  input  logic [2:0]           chip_sel_i,
  input  logic                 adv_i,
  input  logic                 we_i,
  input  logic [NUM_BYTES-1:0] byte_we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    din_i,
  input  logic                 flow_i,
  input  logic                 lin_burst_i,
  input  logic                 sleep_i,
  input  logic                 oe_i,
  output logic [DATA_W-1:0]    dout_o,
  output logic                 dq_drive_o
);

  logic [1:0]           slp_q;
  logic                 asleep;
  op_e                  c1_op;
  logic [ADDR_W-1:0]    c1_addr;
  logic [NUM_BYTES-1:0] c1_be;
  op_e                  c2_op_q;
  logic [ADDR_W-1:0]    c2_addr_q;
  logic [NUM_BYTES-1:0] c2_be_q;
  logic                 wr_fire;
  logic [ADDR_W-1:0]    wr_addr;
  logic [NUM_BYTES-1:0] wr_be;
  logic [DATA_W-1:0]    arr_rdata;
  logic                 rd_valid;
  logic [DATA_W-1:0]    rd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       slp_q <= '0;
    else if (clk_en_i) slp_q <= {slp_q[0], sleep_i};
  end
  assign asleep = slp_q[1];

  lw_sram_cmd #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (clk_en_i),
    .asleep_i (asleep),
    .adv_i    (adv_i),
    .we_i     (we_i),
    .sel_i    (&chip_sel_i),
    .be_i     (byte_we_i),
    .addr_i   (addr_i),
    .linear_i (lin_burst_i),
    .op_o     (c1_op),
    .addr_o   (c1_addr),
    .be_o     (c1_be)
  );

  // second command stage: pipelined writes wait here for their data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_op_q   <= OP_IDLE;
      c2_addr_q <= '0;
      c2_be_q   <= '0;
    end else if (clk_en_i) begin
      c2_op_q   <= c1_op;
      c2_addr_q <= c1_addr;
      c2_be_q   <= c1_be;
    end
  end

  assign wr_fire = clk_en_i && (flow_i ? (c1_op == OP_WRITE) : (c2_op_q == OP_WRITE));
  assign wr_addr = flow_i ? c1_addr : c2_addr_q;
  assign wr_be   = flow_i ? c1_be   : c2_be_q;

  lw_sram_array #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (wr_fire),
    .waddr_i (wr_addr),
    .wbe_i   (wr_be),
    .wdata_i (din_i),
    .raddr_i (c1_addr),
    .rdata_o (arr_rdata)
  );

  lw_sram_rdpath #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_rdpath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (clk_en_i),
    .flow_i     (flow_i),
    .rd_op_i    (c1_op == OP_READ),
    .rd_addr_i  (c1_addr),
    .arr_data_i (arr_rdata),
    .wr_fire_i  (wr_fire),
    .wr_addr_i  (wr_addr),
    .wr_be_i    (wr_be),
    .wr_data_i  (din_i),
    .valid_o    (rd_valid),
    .data_o     (rd_data)
  );

  assign dq_drive_o = rd_valid && oe_i && !asleep;
  assign dout_o     = dq_drive_o ? rd_data : '0;

  assert_oe_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (!dq_drive_o && dout_o == '0));

  assert_quiet_asleep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && slp_q[0]) |=> !dq_drive_o);

  assert_stage2_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(c2_op_q) && $stable(c2_addr_q) && $stable(dout_o) && $stable(slp_q)));

  assert_zero_when_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_drive_o |-> (dout_o == '0));

endmodule

// File: tb/tb_lw_sram.sv
module tb_lw_sram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1;
  logic [2:0]    cs = 3'b000;
  logic          adv = 1'b0;
  logic          we = 1'b0;
  logic [NB-1:0] be = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          flow = 1'b0;
  logic          lin = 1'b1;
  logic          slp = 1'b0;
  logic          oe = 1'b1;
  logic [DW-1:0] dout;
  logic          drv;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lw_sram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(9)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(en), .chip_sel_i(cs), .adv_i(adv),
    .we_i(we), .byte_we_i(be), .addr_i(addr), .din_i(din), .flow_i(flow),
    .lin_burst_i(lin), .sleep_i(slp), .oe_i(oe), .dout_o(dout), .dq_drive_o(drv)
  );

  // apply inputs at a falling edge, return at the next falling edge
  task automatic drive(input logic a_adv, input logic a_we, input logic [2:0] a_cs,
                       input logic [NB-1:0] a_be, input logic [AW-1:0] a_addr,
                       input logic [DW-1:0] a_din);
    adv = a_adv; we = a_we; cs = a_cs; be = a_be; addr = a_addr; din = a_din;
    @(negedge clk);
  endtask

  task automatic nop(input logic [DW-1:0] d);
    drive(1'b0, 1'b0, 3'b000, '0, '0, d);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] b);
    drive(1'b0, 1'b1, 3'b111, b, a, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    drive(1'b0, 1'b0, 3'b111, '0, a, '0);
  endtask

  task automatic chk(input string tag, input logic e_drv, input logic [DW-1:0] e_dat);
    logic [DW-1:0] e_out;
    e_out = e_drv ? e_dat : '0;
    nchk++;
    if (drv !== e_drv || dout !== e_out) begin
      nfail++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, drv, dout, e_drv, e_out);
    end
  endtask

  task automatic t_reset;
    chk("R12 reset outputs", 1'b0, '0);
  endtask

  task automatic t_pipe_mix;
    flow = 1'b0;
    wr(6'd5, 2'b11);
    wr(6'd6, 2'b11);
    drive(1'b0, 1'b0, 3'b111, '0, 6'd5, 18'h1A5A5);
    chk("R2 no data in write slot", 1'b0, '0);
    drive(1'b0, 1'b0, 3'b111, '0, 6'd6, 18'h0F0F0);
    chk("R2 pipelined read latency", 1'b1, 18'h1A5A5);
    wr(6'd7, 2'b11);
    chk("R4 read then write back to back", 1'b1, 18'h0F0F0);
    rd(6'd7);
    chk("R1 write command drives nothing", 1'b0, '0);
    nop(18'h2C3C3);
    chk("R5 read right behind write, full word", 1'b1, 18'h2C3C3);
    nop('0);
    chk("R12 bus released after read", 1'b0, '0);
  endtask

  task automatic t_bypass_bytes;
    logic [DW-1:0] a_w, b_w, m_w;
    a_w = 18'h155AA; b_w = 18'h0A0F3;
    m_w = {a_w[17:9], b_w[8:0]};
    flow = 1'b0;
    wr(6'd9, 2'b11); nop('0); nop(a_w);
    wr(6'd9, 2'b01);
    rd(6'd9);
    nop(b_w);
    chk("R5 partial bypass merge", 1'b1, m_w);
    rd(6'd9);
    nop('0);
    chk("R6 byte write kept upper byte", 1'b1, m_w);
    nop('0); nop('0);
  endtask

  task automatic t_flow;
    logic [DW-1:0] d_w, e_w;
    d_w = 18'h12345; e_w = 18'h3CAFE;
    flow = 1'b1;
    wr(6'd12, 2'b11);
    drive(1'b0, 1'b0, 3'b111, '0, 6'd12, d_w);
    chk("R3 flow-through read after write", 1'b1, d_w);
    wr(6'd12, 2'b10);
    drive(1'b0, 1'b0, 3'b111, '0, 6'd12, e_w);
    chk("R6 flow-through upper byte only", 1'b1, {e_w[17:9], d_w[8:0]});
    nop('0);
    chk("R3 flow-through release", 1'b0, '0);
    flow = 1'b0;
    nop('0); nop('0);
  endtask

  task automatic t_burst;
    flow = 1'b0;
    lin = 1'b1;
    wr(6'h11, 2'b11);
    drive(1'b1, 1'b0, 3'b000, 2'b11, '0, '0);
    drive(1'b1, 1'b0, 3'b000, 2'b11, '0, 18'h10000);
    drive(1'b1, 1'b0, 3'b000, 2'b11, '0, 18'h20001);
    nop(18'h30002);
    nop(18'h00003);
    // words: 0x11=10000 0x12=20001 0x13=30002 0x10=00003
    lin = 1'b0;
    rd(6'h12);
    drive(1'b1, 1'b1, 3'b000, '0, '0, '0);
    chk("R7 interleaved beat0", 1'b1, 18'h20001);
    drive(1'b1, 1'b1, 3'b000, '0, '0, '0);
    chk("R7 interleaved beat1", 1'b1, 18'h30002);
    drive(1'b1, 1'b1, 3'b000, '0, '0, '0);
    chk("R7 interleaved beat2", 1'b1, 18'h00003);
    nop('0);
    chk("R7 interleaved beat3", 1'b1, 18'h10000);
    lin = 1'b1;
    rd(6'h13);
    drive(1'b1, 1'b0, 3'b000, '0, '0, '0);
    chk("R7 linear beat0", 1'b1, 18'h30002);
    nop('0);
    chk("R7 linear wrap beat1", 1'b1, 18'h00003);
    nop('0);
  endtask

  task automatic t_deselect;
    flow = 1'b0;
    wr(6'h20, 2'b11); nop('0); nop(18'h2AAAA);
    drive(1'b0, 1'b1, 3'b101, 2'b11, 6'h20, '0);
    drive(1'b1, 1'b1, 3'b111, 2'b11, '0, '0);
    nop(18'h3FFFF); nop(18'h3FFFF);
    rd(6'h20);
    nop('0);
    chk("R8 deselected write left word", 1'b1, 18'h2AAAA);
    drive(1'b0, 1'b0, 3'b011, '0, 6'h20, '0);
    nop('0);
    chk("R8 deselected read drives nothing", 1'b0, '0);
  endtask

  task automatic t_clk_en;
    flow = 1'b0;
    rd(6'h11);
    rd(6'h12);
    chk("R9 first read out", 1'b1, 18'h10000);
    en = 1'b0;
    rd(6'h13);
    chk("R9 stalled edge holds output", 1'b1, 18'h10000);
    nop('0);
    chk("R9 second stalled edge", 1'b1, 18'h10000);
    en = 1'b1;
    nop('0);
    chk("R9 resumes with held command", 1'b1, 18'h20001);
    nop('0);
    chk("R9 stalled command discarded", 1'b0, '0);
  endtask

  task automatic t_sleep;
    flow = 1'b0;
    wr(6'h30, 2'b11); nop('0); nop(18'h15555);
    slp = 1'b1;
    nop('0);
    rd(6'h30);
    wr(6'h30, 2'b11);
    chk("R10 outputs quiet while asleep", 1'b0, '0);
    nop(18'h00000);
    rd(6'h30);
    chk("R10 read ignored while asleep", 1'b0, '0);
    slp = 1'b0;
    nop('0); nop('0);
    rd(6'h30);
    nop('0);
    chk("R10 contents kept, slept write ignored", 1'b1, 18'h15555);
  endtask

  task automatic t_oe;
    flow = 1'b0;
    rd(6'h30);
    nop('0);
    oe = 1'b0;
    #1;
    chk("R11 output enable off mid-cycle", 1'b0, '0);
    oe = 1'b1;
    #1;
    chk("R11 output enable restored", 1'b1, 18'h15555);
    @(negedge clk);
    nop('0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_pipe_mix;
    t_bypass_bytes;
    t_flow;
    t_burst;
    t_deselect;
    t_clk_en;
    t_sleep;
    t_oe;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule